// File: doc/BRIEF.md
# Scratchpad-Staged Write-Once Memory Controller

This block models a small write-once memory and the guarded write flow around it. It holds 128 bytes of data storage, split into four pages of 32 bytes, and eight status locations. Status locations 0 through 6 are write-once. Status location 7 is ordinary RAM that holds seven control bits, and its top bit shows a supply indication taken from an input pin.

A host never writes the array directly. A load request places a target and a byte in a one-byte scratchpad. On the next cycle the block returns a 16-bit check code over the command, address and data, so the host can confirm that the block received them. Only an explicit commit then moves the scratchpad into the target. A write-once target commits on a programming strobe. The RAM location commits when a dummy byte of 0xFF arrives.

Programming can only clear bits. Write-protect bits in status location 0 block programming of the matching data page.

Top module: `otp_stage_mem`

## Requirements
- R1: After reset every data byte and status locations 0 to 5 read 0xFF. Status location 6 reads 0x00. Status location 7 reads {supply_ind, 7'b0}. crc_valid and prog_err are low.
- R2: A cycle with wr_req high loads the scratchpad. In the next cycle crc_valid is high for exactly one cycle and crc_out carries the check code. The code is CRC-16 with polynomial x^16+x^15+x^2+1 (reflected constant 0xA001) and initial value 0. It is fed LSB first with, in order: the command byte (0x0F for the data space, 0x55 for the status space), the address low byte, the address high byte, and the data byte. The address is zero-extended to 16 bits, and a status address uses only wr_addr[2:0]. crc_out is the bitwise inverse of the result.
- R3: A programming strobe that follows a fresh load aimed at a write-once location sets that location to its old value ANDed with the scratchpad byte.
- R4: A ram_byte_valid strobe carrying 0xFF that follows a fresh load aimed at status location 7 writes scratchpad bits 6..0 into it. Bit 7 always reads as supply_ind.
- R5: Bit n of status location 0, for n from 0 to 3, is the write-protect bit of data page n, and the page is protected when the bit is 0. A programming commit aimed at a protected page leaves the memory unchanged and pulses prog_err high for one cycle, in the cycle after the strobe.
- R6: Any commit strobe uses up the scratchpad. A second commit strobe without a new load changes nothing.
- R7: A 0xFF byte aimed at a write-once location, a programming strobe aimed at status location 7, and a RAM byte other than 0xFF each change no memory.
- R8: Status location 6 always reads 0x00, whatever has been programmed into it.
- R9: A cycle with rd_req high gives rd_valid high, with rd_data holding the addressed byte, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ind | input | 1 | Supply indication, shown as bit 7 of status location 7 |
| wr_req | input | 1 | Load the scratchpad |
| wr_space | input | 1 | Load target space: 0 data, 1 status |
| wr_addr | input | 7 | Load target address |
| wr_data | input | 8 | Byte to stage |
| crc_valid | output | 1 | One-cycle pulse when crc_out is new |
| crc_out | output | 16 | Inverted check code over command, address and data |
| prog_pulse | input | 1 | Programming commit strobe for write-once targets |
| ram_byte_valid | input | 1 | A commit byte is present on ram_byte |
| ram_byte | input | 8 | Commit byte; only 0xFF commits the RAM location |
| prog_err | output | 1 | One-cycle pulse when a commit hits a protected page |
| rd_req | input | 1 | Read request |
| rd_space | input | 1 | Read space: 0 data, 1 status |
| rd_addr | input | 7 | Read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |

## Verification
Every result is one register stage away from its stimulus. The check code, the error pulse and read data all appear in the cycle after the edge that captured the load, commit or read request. Commits take effect at their own edge, so a read issued on the following cycle returns the new value. The bench drives each strobe for one cycle on the falling edge. It samples on the next falling edge, which is the single cycle in which the pulsed outputs are defined, and it checks that these pulses have dropped again one cycle later.

// File: rtl/otp_stage_mem.sv
module otp_stage_mem #(
  parameter int DBYTES = 128,
  parameter int PAGE_BYTES = 32,
  parameter logic [7:0] CMD_DATA = 8'h0F,
  parameter logic [7:0] CMD_STAT = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        supply_ind,
  input  logic        wr_req,
  input  logic        wr_space,
  input  logic [6:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        crc_valid,
  output logic [15:0] crc_out,
  input  logic        prog_pulse,
  input  logic        ram_byte_valid,
  input  logic [7:0]  ram_byte,
  output logic        prog_err,
  input  logic        rd_req,
  input  logic        rd_space,
  input  logic [6:0]  rd_addr,
  output logic        rd_valid,
  output logic [7:0]  rd_data
);
  localparam int PAGES = DBYTES / PAGE_BYTES;
  localparam int PW = $clog2(PAGES);
  localparam int AW = $clog2(DBYTES);
  localparam int PSHIFT = $clog2(PAGE_BYTES);

  logic [DBYTES-1:0][7:0] dmem;
  logic [6:0][7:0]        smem;
  logic [6:0]             ctrl;
  logic [7:0]             sp;
  logic                   sp_space;
  logic [6:0]             sp_addr;
  logic                   armed;

  function automatic logic [15:0] crc16(input logic [31:0] stream);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 0; i < 32; i++) begin
      if (c[0] ^ stream[i]) c = (c >> 1) ^ 16'hA001;
      else                  c = c >> 1;
    end
    return ~c;
  endfunction

  logic [15:0] wr_addr16;
  assign wr_addr16 = wr_space ? {13'd0, wr_addr[2:0]} : {{(16-AW){1'b0}}, wr_addr[AW-1:0]};

  logic sp_is_ram, sp_protected;
  logic [PW-1:0] sp_page;
  assign sp_is_ram    = sp_space && (sp_addr[2:0] == 3'd7);
  assign sp_page      = sp_addr[PSHIFT +: PW];
  assign sp_protected = !sp_space && !smem[0][sp_page];

  logic do_prog, do_ram;
  assign do_prog = armed && prog_pulse && !sp_is_ram && !sp_protected;
  assign do_ram  = armed && !prog_pulse && ram_byte_valid && ram_byte == 8'hFF && sp_is_ram;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      sp        <= 8'hFF;
      sp_space  <= 1'b0;
      sp_addr   <= '0;
      crc_valid <= 1'b0;
      crc_out   <= '0;
    end else begin
      crc_valid <= wr_req;
      if (wr_req) begin
        armed    <= 1'b1;
        sp       <= wr_data;
        sp_space <= wr_space;
        sp_addr  <= wr_addr;
        crc_out  <= crc16({wr_data, wr_addr16[15:8], wr_addr16[7:0],
                           wr_space ? CMD_STAT : CMD_DATA});
      end else if (prog_pulse || ram_byte_valid) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmem     <= '1;
      smem     <= '1;
      ctrl     <= '0;
      prog_err <= 1'b0;
    end else begin
      prog_err <= armed && prog_pulse && !sp_is_ram && sp_protected;
      if (do_prog) begin
        if (sp_space) smem[sp_addr[2:0]] <= smem[sp_addr[2:0]] & sp;
        else          dmem[sp_addr[AW-1:0]] <= dmem[sp_addr[AW-1:0]] & sp;
      end
      if (do_ram) ctrl <= sp[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (!rd_space)                  rd_data <= dmem[rd_addr[AW-1:0]];
        else if (rd_addr[2:0] == 3'd7)  rd_data <= {supply_ind, ctrl};
        else if (rd_addr[2:0] == 3'd6)  rd_data <= 8'h00;
        else                            rd_data <= smem[rd_addr[2:0]];
      end
    end
  end

  p_crc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> crc_valid);
  p_crc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !crc_valid);
  p_only_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((dmem & ~$past(dmem)) == '0) && ((smem & ~$past(smem)) == '0));
  p_ram_needs_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(ram_byte_valid && ram_byte == 8'hFF && armed));
  p_err_needs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |-> $past(prog_pulse && armed));
  p_err_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |-> $stable(dmem));
  p_stale_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_req) |=> ($stable(dmem) && $stable(smem) && $stable(ctrl)));
  p_stat6_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_space && rd_addr[2:0] == 3'd6) |=> rd_data == 8'h00);
  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
endmodule

// File: tb/otp_stage_mem_tb.sv
module otp_stage_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {space, addr[6:0], data, expected read}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 7'h05, 8'hA5, 8'hA5},
    {1'b0, 7'h05, 8'h0F, 8'h05},
    {1'b0, 7'h7F, 8'h3C, 8'h3C},
    {1'b0, 7'h20, 8'h00, 8'h00},
    {1'b1, 7'h01, 8'hFE, 8'hFE},
    {1'b1, 7'h05, 8'h12, 8'h12},
    {1'b1, 7'h06, 8'h00, 8'h00},
    {1'b1, 7'h00, 8'hF7, 8'hF7}
  };

  logic clk = 0, rst_n = 0, supply_ind = 0;
  logic wr_req = 0, wr_space = 0, prog_pulse = 0, ram_byte_valid = 0, rd_req = 0, rd_space = 0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, ram_byte = '0;
  logic crc_valid, prog_err, rd_valid;
  logic [15:0] crc_out;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_stage_mem u_dut (.clk(clk), .rst_n(rst_n), .supply_ind(supply_ind),
    .wr_req(wr_req), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .crc_valid(crc_valid), .crc_out(crc_out), .prog_pulse(prog_pulse),
    .ram_byte_valid(ram_byte_valid), .ram_byte(ram_byte), .prog_err(prog_err),
    .rd_req(rd_req), .rd_space(rd_space), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic space, input logic [6:0] a, input logic [7:0] d);
    logic [7:0] bytes [4];
    logic [15:0] r;
    bytes[0] = space ? 8'h55 : 8'h0F;
    bytes[1] = space ? {5'd0, a[2:0]} : {1'b0, a};
    bytes[2] = 8'h00;
    bytes[3] = d;
    r = 0;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = r[0] ^ bytes[b][k];
        r = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'hA001;
      end
    return ~r;
  endfunction

  task automatic load(input logic space, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr_req = 1; wr_space = space; wr_addr = a; wr_data = d;
    @(negedge clk); wr_req = 0;
    check("R2 crc_valid", {31'd0, crc_valid}, 1);
    check("R2 crc_out", {16'd0, crc_out}, {16'd0, ref_crc(space, a, d)});
    @(negedge clk);
    check("R2 crc_valid drop", {31'd0, crc_valid}, 0);
  endtask

  task automatic prog(input logic exp_err, input string req);
    @(negedge clk); prog_pulse = 1;
    @(negedge clk); prog_pulse = 0;
    check(req, {31'd0, prog_err}, {31'd0, exp_err});
  endtask

  task automatic rambyte(input logic [7:0] b);
    @(negedge clk); ram_byte_valid = 1; ram_byte = b;
    @(negedge clk); ram_byte_valid = 0;
  endtask

  task automatic rd(input logic space, input logic [6:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd_req = 1; rd_space = space; rd_addr = a;
    @(negedge clk); rd_req = 0;
    check("R9 rd_valid", {31'd0, rd_valid}, 1);
    check(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 crc_valid reset", {31'd0, crc_valid}, 0);
    check("R1 prog_err reset", {31'd0, prog_err}, 0);
    rd(0, 7'h00, 8'hFF, "R1 data reset");
    rd(0, 7'h7F, 8'hFF, "R1 data reset top");
    rd(1, 7'h03, 8'hFF, "R1 status reset");
    rd(1, 7'h06, 8'h00, "R1 status6 reset");
    rd(1, 7'h07, 8'h00, "R1 status7 reset");

    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][23], VEC[i][22:16], VEC[i][15:8]);
      prog(0, "R3 no err");
      rd(VEC[i][23], VEC[i][22:16], VEC[i][7:0], VEC[i][23] ? "R3/R8 status program" : "R3 data program");
    end

    // R5: page 3 now protected
    load(0, 7'h60, 8'h00);
    prog(1, "R5 prog_err pulse");
    @(negedge clk);
    check("R5 prog_err one cycle", {31'd0, prog_err}, 0);
    rd(0, 7'h60, 8'hFF, "R5 protected page unchanged");
    load(0, 7'h40, 8'h81);
    prog(0, "R5 unprotected page no err");
    rd(0, 7'h40, 8'h81, "R5 unprotected page written");

    // R6 and R7: non-FF byte consumes scratchpad, then stale programming strobe
    load(0, 7'h13, 8'h00);
    rambyte(8'hAB);
    prog(0, "R6 stale no err");
    rd(0, 7'h13, 8'hFF, "R6 stale commit ignored");
    load(0, 7'h14, 8'h00);
    rambyte(8'hFF);
    rd(0, 7'h14, 8'hFF, "R7 FF to write-once ignored");
    load(1, 7'h07, 8'h55);
    prog(0, "R7 no err on RAM");
    rd(1, 7'h07, 8'h00, "R7 pulse to RAM ignored");
    load(1, 7'h07, 8'h2A);
    rambyte(8'h7F);
    rd(1, 7'h07, 8'h00, "R7 non-FF byte ignored");

    // R4
    load(1, 7'h07, 8'hAA);
    rambyte(8'hFF);
    rd(1, 7'h07, 8'h2A, "R4 RAM commit, bit7 from supply");
    supply_ind = 1;
    rd(1, 7'h07, 8'hAA, "R4 supply bit");
    rambyte(8'hFF);
    load(1, 7'h07, 8'h01);
    rambyte(8'hFF);
    rd(1, 7'h07, 8'h81, "R4 RAM rewrite sets bits");
    rambyte(8'hFF);
    rd(1, 7'h07, 8'h81, "R6 repeat FF ignored");

    // R8 after programming
    rd(1, 7'h06, 8'h00, "R8 status6 reads zero");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule